// File: doc/BRIEF.md
# Steerable Bridge PWM Generator

This block produces one pulse-width-modulated waveform and routes it to up to four output lines, A to D, each with its own output enable. The period is set by an 8-bit period register. The time base is a 10-bit count: an 8-bit timer sits above two low sub-count bits. The time base moves forward by one step on each clock cycle in which `tick` is high. The duty value is 10 bits wide. Its upper eight bits live in a duty register and its lower two bits in the control register.

Duty is double-buffered. A working copy of the written duty is taken only at the start of each period, so software can change duty at any moment without producing a distorted pulse. A 2-bit steering field selects one of four routings:
- a single output on A;
- a complementary half-bridge pair on A and B;
- a forward full bridge;
- a reverse full bridge.

Two polarity bits select active-high or active-low levels for the A/C pair and for the B/D pair.

The time base is a three-state machine:
- `TB_OFF`: stopped.
- `TB_ACT`: pulse active.
- `TB_IDLE`: pulse inactive.

Its transitions are:
- start (`TB_OFF` or period end to `TB_ACT`/`TB_IDLE`);
- duty match (`TB_ACT` to `TB_IDLE`);
- disable (any state to `TB_OFF`).

Top module: `pwm_bridge_drv`

## Requirements
- R1: Register writes use `wr_addr` 0 for the period, 1 for the upper eight duty bits, and 2 for control. In the control byte, bits [7:6] are the steering field, bits [5:4] are the two low duty bits, and bits [3:0] are the mode select. All registers reset to zero, so after reset every output and enable is 0.
- R2: While running, the 10-bit time base counts 0 up to {period, 2'b11} and then restarts at 0. A period therefore lasts (period+1)*4 ticks.
- R3: The first tick after the block is enabled starts a period at count 0. The PWM signal is active exactly while the time base is below the working duty.
- R4: The working duty is loaded from {duty register, control[5:4]} only when a period starts. A duty write in mid-period changes nothing until the next period.
- R5: A working duty of 0 gives a signal that is never active. A working duty of (period+1)*4 or more gives a signal that is always active.
- R6: The block runs only while mode select [3:2] is 2'b11. Otherwise all outputs and enables are 0 and the time base stays at `TB_OFF`.
- R7: Steering 2'b00 (single): A carries the PWM signal, and the enables are 4'b0001. Enable and output bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D.
- R8: Steering 2'b10 (half bridge): A carries the PWM signal, B carries its complement, and the enables are 4'b0011.
- R9: Steering 2'b01 (forward full bridge): A is held active, D carries the PWM signal, B and C are inactive, and the enables are 4'b1111.
- R10: Steering 2'b11 (reverse full bridge): C is held active, B carries the PWM signal, A and D are inactive, and the enables are 4'b1111.
- R11: Mode select bit 0 set makes A and C active-low. Mode select bit 1 set makes B and D active-low. Inactive lines then sit at 1.
- R12: Writing 0 to the control register drives all outputs and enables to 0 in the cycle that follows the write.
- R13: In a cycle with `tick` low, the time base, the working duty and the PWM state do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 duty high, 2 control |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Time base clock enable |
| pwm_out | output | 4 | Output levels, bit 0 = A through bit 3 = D |
| pwm_oe | output | 4 | Output enables, same bit order |

## Verification
A register write or a tick takes effect at a rising edge, and the outputs show the result from that edge onwards. This holds because the outputs decode only the registered state and the registered control byte. The bench keeps a behavioural model that it updates at the same rising edge, using the inputs that were driven half a cycle earlier. It compares both output buses with the model at every falling edge. Directed checks, such as zero duty, full duty, disable and a cleared control register, sample at falling edges a set number of cycles after the write: one cycle for a control change, and at least one full period for a duty change.

// File: rtl/epwm_pkg.sv
`timescale 1ns/1ps
package epwm_pkg;
    typedef enum logic [1:0] {
        TB_OFF  = 2'd0,
        TB_ACT  = 2'd1,
        TB_IDLE = 2'd2
    } tb_state_e;

    typedef enum logic [1:0] {
        ST_SINGLE = 2'b00,
        ST_FWD    = 2'b01,
        ST_HALF   = 2'b10,
        ST_REV    = 2'b11
    } steer_e;

    localparam logic [1:0] ADDR_PERIOD = 2'd0;
    localparam logic [1:0] ADDR_DUTY   = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;
    localparam int         SUB_W       = 2;
endpackage

// File: rtl/epwm_regs.sv
`timescale 1ns/1ps
module epwm_regs
    import epwm_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    output logic [TMR_W-1:0] period,
    output logic [TMR_W-1:0] duty_hi,
    output logic [7:0]       ctrl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period  <= '0;
            duty_hi <= '0;
            ctrl    <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_PERIOD: period  <= wr_data;
                ADDR_DUTY:   duty_hi <= wr_data;
                ADDR_CTRL:   ctrl    <= wr_data[7:0];
                default:     ;
            endcase
        end
    end

    // R12: a write of zero to control clears it on the next edge
    a_r12_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && wr_data[7:0] == 8'd0) |=> ctrl == 8'd0);
endmodule

// File: rtl/epwm_timebase.sv
`timescale 1ns/1ps
module epwm_timebase
    import epwm_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [TMR_W-1:0] period,
    input  logic [TMR_W+SUB_W-1:0] duty,
    output logic             pwm_active
);
    localparam int CNT_W = TMR_W + SUB_W;

    tb_state_e        state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic [CNT_W-1:0] shadow, nxt_shadow;
    logic             at_end;

    assign at_end = (cnt == {period, {SUB_W{1'b1}}});

    always_comb begin
        nxt_state  = state;
        nxt_cnt    = cnt;
        nxt_shadow = shadow;
        if (!en) begin
            nxt_state = TB_OFF;
            nxt_cnt   = '0;
        end else if (tick) begin
            unique case (state)
                TB_OFF: begin
                    nxt_cnt    = '0;
                    nxt_shadow = duty;
                    nxt_state  = (duty == '0) ? TB_IDLE : TB_ACT;
                end
                TB_ACT: begin
                    if (at_end) begin
                        nxt_cnt    = '0;
                        nxt_shadow = duty;
                        nxt_state  = (duty == '0) ? TB_IDLE : TB_ACT;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                        if (nxt_cnt == shadow) nxt_state = TB_IDLE;
                    end
                end
                TB_IDLE: begin
                    if (at_end) begin
                        nxt_cnt    = '0;
                        nxt_shadow = duty;
                        nxt_state  = (duty == '0) ? TB_IDLE : TB_ACT;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
                default: nxt_state = TB_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= TB_OFF;
            cnt    <= '0;
            shadow <= '0;
        end else begin
            state  <= nxt_state;
            cnt    <= nxt_cnt;
            shadow <= nxt_shadow;
        end
    end

    assign pwm_active = (state == TB_ACT);

    a_r6_stop_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == TB_OFF);
    a_r13_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick && state != TB_OFF) |=> ($stable(cnt) && $stable(shadow) && $stable(state)));
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && state != TB_OFF && !at_end) |=> cnt == $past(cnt) + 1'b1);
    a_r4_shadow_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TB_OFF && !(tick && at_end)) |=> $stable(shadow));
    a_r5_zero_duty_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TB_OFF && shadow == '0) |-> state == TB_IDLE);
endmodule

// File: rtl/epwm_steer.sv
`timescale 1ns/1ps
module epwm_steer
    import epwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       pwm_active,
    input  logic [1:0] steer,
    input  logic [1:0] pol,
    output logic [3:0] out,
    output logic [3:0] oe
);
    logic [3:0] lvl;
    logic [3:0] pol_mask;

    assign pol_mask = {pol[1], pol[0], pol[1], pol[0]};

    always_comb begin
        lvl = 4'b0000;
        oe  = 4'b0000;
        if (en) begin
            unique case (steer_e'(steer))
                ST_SINGLE: begin lvl = {3'b000, pwm_active};               oe = 4'b0001; end
                ST_HALF:   begin lvl = {2'b00, ~pwm_active, pwm_active};   oe = 4'b0011; end
                ST_FWD:    begin lvl = {pwm_active, 3'b001};               oe = 4'b1111; end
                ST_REV:    begin lvl = {1'b0, 1'b1, pwm_active, 1'b0};     oe = 4'b1111; end
                default:   begin lvl = 4'b0000;                            oe = 4'b0000; end
            endcase
        end
    end

    assign out = en ? (lvl ^ pol_mask) : 4'b0000;

    a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (out == 4'b0000 && oe == 4'b0000));
    a_r8_half_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (en && steer == ST_HALF) |-> ((out[0] ^ pol[0]) != (out[1] ^ pol[1])));
    a_r9_fwd_a_held: assert property (@(posedge clk) disable iff (!rst_n)
        (en && steer == ST_FWD) |-> ((out[0] ^ pol[0]) && !(out[1] ^ pol[1]) && !(out[2] ^ pol[0])));
    a_r10_rev_c_held: assert property (@(posedge clk) disable iff (!rst_n)
        (en && steer == ST_REV) |-> ((out[2] ^ pol[0]) && !(out[0] ^ pol[0]) && !(out[3] ^ pol[1])));
endmodule

// File: rtl/pwm_bridge_drv.sv
`timescale 1ns/1ps
module pwm_bridge_drv
    import epwm_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    input  logic             tick,
    output logic [3:0]       pwm_out,
    output logic [3:0]       pwm_oe
);
    localparam int DUTY_W = TMR_W + SUB_W;

    logic [TMR_W-1:0]  period;
    logic [TMR_W-1:0]  duty_hi;
    logic [7:0]        ctrl;
    logic [DUTY_W-1:0] duty;
    logic              en;
    logic              pwm_active;

    epwm_regs #(.TMR_W(TMR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .period(period), .duty_hi(duty_hi), .ctrl(ctrl)
    );

    assign duty = {duty_hi, ctrl[5:4]};
    assign en   = (ctrl[3:2] == 2'b11);

    epwm_timebase #(.TMR_W(TMR_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .period(period), .duty(duty), .pwm_active(pwm_active)
    );

    epwm_steer u_steer (
        .clk(clk), .rst_n(rst_n), .en(en), .pwm_active(pwm_active),
        .steer(ctrl[7:6]), .pol(ctrl[1:0]), .out(pwm_out), .oe(pwm_oe)
    );

    // R7: single mode only ever enables line A
    a_r7_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ctrl[7:6] == 2'b00) |-> pwm_oe == 4'b0001);
endmodule

// File: tb/tb_pwm_bridge_drv.sv
`timescale 1ns/1ps
module tb_pwm_bridge_drv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       tick = 1'b0;
    logic [3:0] pwm_out;
    logic [3:0] pwm_oe;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";
    bit    rand_tick = 0;
    logic [7:0] lf = 8'hA5;

    always #2 clk = ~clk;

    pwm_bridge_drv dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    // behavioural reference model
    int   m_per, m_dhi, m_ctrl, m_cnt, m_shadow;
    bit   m_run;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_per = 0; m_dhi = 0; m_ctrl = 0; m_cnt = 0; m_shadow = 0; m_run = 0;
        end else begin
            if (((m_ctrl >> 2) & 3) != 3) begin
                m_run = 0; m_cnt = 0;
            end else if (tick) begin
                if (!m_run || m_cnt == m_per * 4 + 3) begin
                    m_cnt = 0;
                    m_shadow = m_dhi * 4 + ((m_ctrl >> 4) & 3);
                    m_run = 1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (wr_en) begin
                if (wr_addr == 2'd0) m_per = wr_data;
                else if (wr_addr == 2'd1) m_dhi = wr_data;
                else if (wr_addr == 2'd2) m_ctrl = wr_data;
            end
        end
    end

    function automatic logic [7:0] model_pins();
        logic [3:0] l, o, pm;
        bit p, en;
        en = ((m_ctrl >> 2) & 3) == 3;
        p  = m_run && (m_cnt < m_shadow);
        l = 4'b0; o = 4'b0;
        if (!en) return 8'h00;
        case ((m_ctrl >> 6) & 3)
            0: begin l[0] = p; o = 4'b0001; end
            2: begin l[0] = p; l[1] = !p; o = 4'b0011; end
            1: begin l[0] = 1; l[3] = p; o = 4'b1111; end
            default: begin l[2] = 1; l[1] = p; o = 4'b1111; end
        endcase
        pm = {m_ctrl[1], m_ctrl[0], m_ctrl[1], m_ctrl[0]};
        return {o, l ^ pm};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) check(cur_req, {pwm_oe, pwm_out}, model_pins());
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rand_tick) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                tick = lf[0] | lf[2];
            end else begin
                tick = 1'b1;
            end
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", {pwm_oe, pwm_out}, 8'h00);

        // R2 R3 R7: period 3 (16 ticks), duty 6, single mode
        cur_req = "R7";
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd1);
        wr(2'd2, 8'b00_10_1100);
        run(50);
        cur_req = "R3";

        // R4: mid-period duty change
        cur_req = "R4";
        run(5);
        wr(2'd1, 8'd3);
        run(40);

        // R13: irregular ticks
        cur_req = "R13";
        rand_tick = 1;
        run(120);
        rand_tick = 0;

        // R8 half bridge, R11 polarity
        cur_req = "R8";
        wr(2'd2, 8'b10_01_1100);
        run(40);
        cur_req = "R11";
        wr(2'd2, 8'b10_01_1111);
        run(40);

        // R9 forward, R10 reverse
        cur_req = "R9";
        wr(2'd2, 8'b01_11_1101);
        run(40);
        cur_req = "R10";
        wr(2'd2, 8'b11_11_1110);
        rand_tick = 1;
        run(80);
        rand_tick = 0;

        // R5: zero duty never active
        cur_req = "R5";
        wr(2'd1, 8'd0);
        wr(2'd2, 8'b00_00_1100);
        run(20);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R5 zero duty", {pwm_oe, pwm_out}, 8'h10);
        end
        // R5: duty beyond period always active
        wr(2'd1, 8'd255);
        wr(2'd2, 8'b00_11_1100);
        run(20);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R5 full duty", {pwm_oe, pwm_out}, 8'h11);
        end

        // R6: mode select not 11 disables everything
        cur_req = "R6";
        wr(2'd2, 8'b01_11_1011);
        check("R6 disabled", {pwm_oe, pwm_out}, 8'h00);
        run(10);
        check("R6 disabled", {pwm_oe, pwm_out}, 8'h00);

        // R12: clear control while running
        cur_req = "R12";
        wr(2'd2, 8'b01_00_1100);
        wr(2'd1, 8'd2);
        run(30);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        check("R12 cleared", {pwm_oe, pwm_out}, 8'h00);
        run(5);
        finish_run();
    end
endmodule